// File: doc/BRIEF.md
# Bit-Order Selectable Serial Shifter

This block is a synchronous serial port that moves one byte per transfer over three wires: a shift clock, an outgoing data line and an incoming data line. Software first sets a small control register. The register chooses whether the port both sends and receives or only receives. It chooses which end of the byte goes on the wire first. It also chooses whether the shift clock comes from an internal divider or from another device. Writing a byte to the data register while the port is idle starts a transfer.

During a transfer, incoming data is captured on each rising shift-clock edge and outgoing data advances on each falling edge. After the last rising edge the port raises a sticky completion flag and a one-cycle interrupt request, and the assembled byte appears on a read register. When the clock comes from outside, the pin is brought into the system clock domain through a flop chain and edge-detected there, so the whole block runs on one clock.

Top module: `sio_shifter`

## Requirements
- R1: A data write while idle (tx_we high, busy low) sets busy on the next edge. The transfer is exactly W shift-clock rising edges, W = 8 by default. No further shift-clock edge appears once busy has dropped.
- R2: With ctl bit 1 (lsb_first) set, wire bit k carries tx bit k, and the k-th bit captured from si lands in rx_byte bit k.
- R3: With lsb_first clear, wire bit k carries tx bit W-1-k, and the k-th captured bit lands in rx_byte bit W-1-k.
- R4: With ctl bit 0 (rx_only) set, so_oe is low and so_o stays high for the whole transfer, while si is still captured into rx_byte. With rx_only clear, so_oe is high.
- R5: si is sampled on the rising shift-clock edge. so_o changes only on a falling shift-clock edge, except that the first bit is presented when the transfer starts.
- R6: With ctl bit 2 (ext_clk) clear, sck_oe is high and sck_o idles high. The shift-clock period is 4, 16, 64 or 256 system clocks for ctl bits 4:3 equal to 0, 1, 2 or 3.
- R7: With ext_clk set, sck_oe is low and sck_o is held high. Each transfer is clocked by the edges of sck_in after a synchronizer of SYNC_STAGES flops.
- R8: On the last rising edge, rx_byte is updated, done is set and irq pulses high for exactly one cycle. done clears when the next transfer starts, and rx_byte changes at no other time.
- R9: Writes to either the data or the control register while busy is high are ignored.
- R10: After reset the outputs read busy=0, done=0, irq=0, rx_byte=0, sck_o=1, sck_oe=1, so_o=1 and so_oe=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control value: [0] rx_only, [1] lsb_first, [2] ext_clk, [4:3] divider select |
| tx_we | input | 1 | Data write strobe; starts a transfer when idle |
| tx_wdata | input | W | Byte to send |
| sck_in | input | 1 | Shift clock from another device |
| si | input | 1 | Serial data in |
| sck_o | output | 1 | Shift clock out |
| sck_oe | output | 1 | Shift clock drive enable |
| so_o | output | 1 | Serial data out |
| so_oe | output | 1 | Serial data drive enable |
| rx_byte | output | W | Last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest situation to reach from the ports is a register write that arrives in the middle of a transfer. A correct design must drop it without leaving any trace in the bit stream. The bench reaches it by watching sck_o while it plays the remote side. At the third captured rising edge it pulses both write strobes with a different byte and a control value that sets receive-only. It then checks that the remaining wire bits still match the original byte and that so_oe never fell. The externally clocked case is also delicate, because every edge lags the pin by the synchronizer depth. The bench therefore holds each sck_in phase for six clocks and samples so_o just before raising the clock.

// File: rtl/sio_pkg.sv
package sio_pkg;
   // Control register layout (LSB first): rx_only, lsb_first, ext_clk, div_sel[1:0]
   typedef struct packed {
      logic [1:0] div_sel;
      logic       ext_clk;
      logic       lsb_first;
      logic       rx_only;
   } sio_ctl_t;

   localparam int CTL_W = $bits(sio_ctl_t);
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
   parameter int BASE_LOG2 = 2,
   parameter int STEP_LOG2 = 2,
   parameter int SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] div_sel,
   output logic             sck,
   output logic             rise_ev,
   output logic             fall_ev
);
   localparam int NSEL = 1 << SEL_W;
   localparam int HC_W = BASE_LOG2 - 1 + STEP_LOG2 * (NSEL - 1);

   logic [HC_W-1:0] term [NSEL];
   logic [HC_W-1:0] hc;
   logic            hit;

   // half-period terminal count for each divider choice
   for (genvar g = 0; g < NSEL; g++) begin : g_term
      assign term[g] = HC_W'((1 << (BASE_LOG2 - 1 + STEP_LOG2 * g)) - 1);
   end

   assign hit     = run && (hc == term[div_sel]);
   assign rise_ev = hit && !sck;
   assign fall_ev = hit && sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc  <= '0;
         sck <= 1'b1;
      end else if (!run) begin
         hc  <= '0;
         sck <= 1'b1;
      end else if (hit) begin
         hc  <= '0;
         sck <= ~sck;
      end else begin
         hc  <= hc + 1'b1;
      end
   end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise_ev,
   output logic fall_ev
);
   // STAGES synchronizer flops plus one history flop for edge detection
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], pin};
   end

   assign rise_ev =  chain[STAGES-1] & ~chain[STAGES];
   assign fall_ev = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] tx_byte,
   input  logic         lsb_first,
   input  logic         rx_only,
   input  logic         rise_ev,
   input  logic         fall_ev,
   input  logic         si,
   output logic         busy,
   output logic         done,
   output logic         irq,
   output logic         so_bit,
   output logic [W-1:0] rx_byte
);
   localparam int CNT_W = $clog2(W + 1);

   logic [CNT_W-1:0] cnt;
   logic [W-1:0]     tx_sr, rx_sr, tx_next, rx_next;
   logic             do_rise, do_fall, last;

   assign rx_next = lsb_first ? {si, rx_sr[W-1:1]} : {rx_sr[W-2:0], si};
   assign tx_next = lsb_first ? {1'b1, tx_sr[W-1:1]} : {tx_sr[W-2:0], 1'b1};
   assign do_rise = busy && rise_ev;
   assign do_fall = busy && fall_ev && (cnt != '0);
   assign last    = do_rise && (cnt == CNT_W'(W - 1));
   assign so_bit  = rx_only ? 1'b1 : (lsb_first ? tx_sr[0] : tx_sr[W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         irq     <= 1'b0;
         cnt     <= '0;
         tx_sr   <= '1;
         rx_sr   <= '0;
         rx_byte <= '0;
      end else begin
         irq <= last;
         if (start) begin
            busy  <= 1'b1;
            done  <= 1'b0;
            cnt   <= '0;
            tx_sr <= tx_byte;
         end else begin
            if (do_rise) begin
               rx_sr <= rx_next;
               cnt   <= cnt + 1'b1;
            end
            if (last) begin
               busy    <= 1'b0;
               done    <= 1'b1;
               rx_byte <= rx_next;
            end
            if (do_fall) tx_sr <= tx_next;
         end
      end
   end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
   import sio_pkg::*;
#(
   parameter int W             = 8,
   parameter int DIV_BASE_LOG2 = 2,
   parameter int DIV_STEP_LOG2 = 2,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             tx_we,
   input  logic [W-1:0]     tx_wdata,
   input  logic             sck_in,
   input  logic             si,
   output logic             sck_o,
   output logic             sck_oe,
   output logic             so_o,
   output logic             so_oe,
   output logic [W-1:0]     rx_byte,
   output logic             busy,
   output logic             done,
   output logic             irq
);
   if (W < 2) begin : g_bad_w
      $error("sio_shifter: W must be at least 2");
   end
   if (DIV_BASE_LOG2 < 2) begin : g_bad_div
      $error("sio_shifter: DIV_BASE_LOG2 must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sio_shifter: SYNC_STAGES must be at least 2");
   end

   sio_ctl_t ctl_q;
   logic     start, int_sck, int_rise, int_fall, ext_rise, ext_fall, rise_ev, fall_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ctl_q <= '0;
      else if (ctl_we && !busy) ctl_q <= sio_ctl_t'(ctl_wdata);
   end

   assign start = tx_we && !busy;

   sio_clkgen #(
      .BASE_LOG2 (DIV_BASE_LOG2),
      .STEP_LOG2 (DIV_STEP_LOG2),
      .SEL_W     (2)
   ) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy && !ctl_q.ext_clk),
      .div_sel (ctl_q.div_sel),
      .sck     (int_sck),
      .rise_ev (int_rise),
      .fall_ev (int_fall)
   );

   sio_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (sck_in),
      .rise_ev (ext_rise),
      .fall_ev (ext_fall)
   );

   assign rise_ev = ctl_q.ext_clk ? ext_rise : int_rise;
   assign fall_ev = ctl_q.ext_clk ? ext_fall : int_fall;

   sio_shift_core #(
      .W (W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tx_byte   (tx_wdata),
      .lsb_first (ctl_q.lsb_first),
      .rx_only   (ctl_q.rx_only),
      .rise_ev   (rise_ev),
      .fall_ev   (fall_ev),
      .si        (si),
      .busy      (busy),
      .done      (done),
      .irq       (irq),
      .so_bit    (so_o),
      .rx_byte   (rx_byte)
   );

   assign sck_o  = ctl_q.ext_clk ? 1'b1 : int_sck;
   assign sck_oe = !ctl_q.ext_clk;
   assign so_oe  = !ctl_q.rx_only;
endmodule

// File: rtl/sio_shifter_chk.sv
module sio_shifter_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tx_we,
   input logic         busy,
   input logic         done,
   input logic         irq,
   input logic         sck_o,
   input logic         sck_oe,
   input logic         so_o,
   input logic         so_oe,
   input logic [W-1:0] rx_byte,
   input logic         ctl_rx_only,
   input logic         ctl_ext
);
   p_rxonly_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rx_only |-> (!so_oe && so_o));

   p_so_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !ctl_ext && !ctl_rx_only && (so_o != $past(so_o)))
      |-> $fell(sck_o));

   p_sck_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_o);

   p_ext_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_ext |-> (!sck_oe && sck_o));

   p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done && !busy));

   p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> $stable(rx_byte));

   p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_we) |=> (busy || irq));
endmodule

bind sio_shifter sio_shifter_chk #(.W(W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_we       (tx_we),
   .busy        (busy),
   .done        (done),
   .irq         (irq),
   .sck_o       (sck_o),
   .sck_oe      (sck_oe),
   .so_o        (so_o),
   .so_oe       (so_oe),
   .rx_byte     (rx_byte),
   .ctl_rx_only (ctl_q.rx_only),
   .ctl_ext     (ctl_q.ext_clk)
);

// File: tb/tb_sio_shifter.sv
module tb_sio_shifter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [4:0] ctl_wdata = '0;
   logic       tx_we = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic       sck_in = 1'b1;
   logic       si = 1'b0;
   logic       sck_o, sck_oe, so_o, so_oe, busy, done, irq;
   logic [7:0] rx_byte;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sio_shifter dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .tx_we(tx_we), .tx_wdata(tx_wdata), .sck_in(sck_in), .si(si),
      .sck_o(sck_o), .sck_oe(sck_oe), .so_o(so_o), .so_oe(so_oe),
      .rx_byte(rx_byte), .busy(busy), .done(done), .irq(irq)
   );

   // {ctl = {div[1:0], ext, lsb, rx_only}, tx byte, si bit sequence (bit k = k-th wire bit)}
   localparam logic [20:0] VECS [8] = '{
      {5'b00_0_0_0, 8'hA5, 8'h3C},
      {5'b00_0_1_0, 8'h96, 8'hC1},
      {5'b01_0_1_1, 8'h5A, 8'h81},
      {5'b10_0_0_0, 8'h01, 8'h80},
      {5'b11_0_1_0, 8'hFE, 8'h7F},
      {5'b00_1_0_0, 8'h3C, 8'hE7},
      {5'b00_1_1_1, 8'h00, 8'h5B},
      {5'b00_0_0_1, 8'hC3, 8'h26}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   task automatic write_ctl(input logic [4:0] c);
      @(negedge clk); ctl_wdata = c; ctl_we = 1'b1;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic write_tx(input logic [7:0] d);
      @(negedge clk); tx_wdata = d; tx_we = 1'b1;
      @(negedge clk); tx_we = 1'b0;
   endtask

   task automatic final_checks(input logic [4:0] c, input logic [7:0] tx, input logic [7:0] seq,
                               input logic [7:0] wire_bits, input int irqs, input int oe_bad);
      string rq;
      logic [7:0] exp_wire;
      rq = c[1] ? "R2" : "R3";
      exp_wire = c[0] ? 8'hFF : (c[1] ? tx : rev8(tx));
      chk(wire_bits, exp_wire, c[0] ? "R4" : rq, "wire bit sequence on so_o");
      chk(rx_byte, c[1] ? seq : rev8(seq), rq, "received byte");
      chk(irqs, 1, "R8", "irq pulse count");
      chk({busy, done}, 2'b01, "R8", "busy/done after transfer");
      chk(oe_bad, 0, "R4", "so_oe level during transfer");
   endtask

   task automatic run_int(input logic [4:0] c, input logic [7:0] tx, input logic [7:0] seq,
                          input bit inject);
      int k = 0, nf = 0, irqs = 0, oe_bad = 0, cyc = 0, t0 = 0, t1 = 0, guard = 0, extra = 0;
      logic prev;
      logic [7:0] wire_bits = '0;
      bit injd = 0;
      write_ctl(c);
      si = seq[0];
      write_tx(tx);
      chk({busy, done}, 2'b10, "R1", "busy set and done cleared at start");
      chk(sck_oe, 1, "R6", "internal clock drives sck");
      prev = sck_o;
      while (k < 8 && guard < 6000) begin
         @(negedge clk);
         guard++; cyc++;
         tx_we = 1'b0; ctl_we = 1'b0;
         if (irq) irqs++;
         if (so_oe !== !c[0]) oe_bad++;
         if (sck_o && !prev) begin wire_bits[k] = so_o; k++; end
         if (!sck_o && prev) begin
            if (nf == 0) t0 = cyc; else if (nf == 1) t1 = cyc;
            nf++;
            if (k > 0 && k < 8) si = seq[k];
         end
         if (inject && k == 3 && !injd) begin
            // R9: mid-transfer writes of data and control must be dropped
            tx_wdata = ~tx; tx_we = 1'b1;
            ctl_wdata = c | 5'b00001; ctl_we = 1'b1;
            injd = 1;
         end
         prev = sck_o;
      end
      chk(k, 8, "R1", "rising sck edges in transfer");
      chk(t1 - t0, 4 << (2 * c[4:3]), "R6", "sck period in system clocks");
      for (int j = 0; j < 20; j++) begin
         @(negedge clk);
         if (irq) irqs++;
         if (sck_o !== prev) extra++;
         prev = sck_o;
      end
      chk(extra, 0, "R1", "no sck edge after transfer");
      chk(sck_o, 1, "R6", "sck idles high");
      final_checks(c, tx, seq, wire_bits, irqs, oe_bad);
      if (inject) chk(wire_bits, c[1] ? tx : rev8(tx), "R9", "ignored write left stream unchanged");
   endtask

   task automatic run_ext(input logic [4:0] c, input logic [7:0] tx, input logic [7:0] seq);
      int irqs = 0, oe_bad = 0, sck_bad = 0;
      logic [7:0] wire_bits = '0;
      write_ctl(c);
      sck_in = 1'b1;
      si = seq[0];
      write_tx(tx);
      chk({busy, done}, 2'b10, "R1", "busy set and done cleared at start");
      chk(sck_oe, 0, "R7", "external clock releases sck");
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         sck_in = 1'b0; si = seq[k];
         for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            if (irq) irqs++;
            if (so_oe !== !c[0]) oe_bad++;
            if (sck_o !== 1'b1) sck_bad++;
         end
         wire_bits[k] = so_o;   // R5: sampled just before the rising edge
         sck_in = 1'b1;
         for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            if (irq) irqs++;
         end
      end
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         if (irq) irqs++;
      end
      chk(sck_bad, 0, "R7", "sck_o held high in external mode");
      final_checks(c, tx, seq, wire_bits, irqs, oe_bad);
   endtask

   task automatic main_seq();
      repeat (3) @(negedge clk);
      chk({busy, done, irq}, 3'b000, "R10", "busy/done/irq in reset");
      chk(rx_byte, 8'h00, "R10", "rx_byte in reset");
      chk({sck_o, sck_oe, so_o, so_oe}, 4'b1111, "R10", "pin levels in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({busy, done, irq}, 3'b000, "R10", "idle after reset release");

      for (int i = 0; i < 8; i++) begin
         if (VECS[i][18]) run_ext(VECS[i][20:16], VECS[i][15:8], VECS[i][7:0]);
         else             run_int(VECS[i][20:16], VECS[i][15:8], VECS[i][7:0], i == 1);
      end

      // R8: done persists while idle, rx_byte holds with no transfer
      repeat (10) @(negedge clk);
      chk(done, 1, "R8", "done sticky while idle");
      chk(rx_byte, rev8(8'h26), "R8", "rx_byte held while idle");
      // R9: after a transfer, an idle control write takes effect again
      write_ctl(5'b00_0_0_1);
      chk(so_oe, 0, "R9", "idle control write accepted");
      // back-to-back transfer after completion, MSB first, all-ones / all-zeros corner
      run_int(5'b00_0_0_0, 8'hFF, 8'h00, 1'b0);
      run_int(5'b00_0_1_0, 8'h00, 8'hFF, 1'b0);
   endtask

   initial begin
      fork
         main_seq();
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule